// File: doc/BRIEF.md
# SPI Burst Register Access Slave

This block is an SPI slave that lets an external controller read and write a bank of thirty-two 8-bit configuration registers. An active-low select line frames each access. The first full byte after the select line falls is a command byte holding a coded burst length, a start address and a direction bit. The data bytes that follow are written into, or read out of, consecutive registers. The address wraps from the top of the bank back to zero.

The block contains the serial shift logic, the command decoder, the address and burst sequencer, and the register bank. The bank has a combinational parallel read port for the rest of the chip. Everything runs on one system clock. The serial pins are sampled as ordinary synchronous inputs, so the caller must synchronise them to that clock beforehand. Receive data is taken on each falling SCLK edge, and transmit data advances on that same edge. A byte is committed on its eighth falling edge. Any partial byte is discarded when the select line rises.

Top module: `spi_burst_regs`

## Requirements
- R1: After reset every register reads 0x00 on the host port, and MISO is 0.
- R2: Command byte fields: bits 7:6 are the length code, bits 5:1 are the start address, and bit 0 is the direction. Direction 1 means write, with data taken from MOSI. Direction 0 means read, with data driven on MISO.
- R3: Length code 00 transfers 1 register, 01 transfers 2, 10 transfers 4 and 11 transfers 8. Registers outside the burst are left unchanged.
- R4: A written byte is stored in the bank on the clock edge that detects the eighth falling SCLK edge of that byte. MOSI is sampled MSB first on falling edges.
- R5: In a read, each register value is loaded before the first SCLK edge of its data byte and appears MSB first on MISO. Each bit is held from the previous falling edge until the next falling edge.
- R6: The register address advances by one, modulo 32, after each data byte.
- R7: Bytes that follow a completed burst in the same frame write nothing, and MISO stays 0 during them.
- R8: When the select line rises in the middle of a byte, the partial bits are dropped and no register changes.
- R9: A high select line clears the bit counter and the command state. The first full byte after the select line falls is always taken as a command.
- R10: MISO is 0 whenever the select line is high, during the command byte, and throughout write frames.
- R11: The host port returns the current contents of the register chosen by `host_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the serial pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock from the master, already synchronised |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| host_addr | input | 5 | Parallel read port address |
| host_data | output | 8 | Parallel read port data |

## Verification
The bench drives bursts of every length, including one that wraps from address 30 to 5. A sequencer that stopped at 31 or sized the burst wrongly would either miss registers or overwrite the register just past the burst. After each burst the bench sends one extra byte. A design that failed to stop at the burst end would write that byte or drive it onto MISO. The bench also breaks frames in the middle of a byte, both in a data byte and in a command byte. A design that kept its bit count across frames would store stray data, or would decode the next command one bit out of place. Read bursts check the first bit before any clock edge, which catches a transmit register that is loaded one byte late.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

   // Frame phase of the slave sequencer
   typedef enum logic [1:0] {
      PH_CMD  = 2'd0,   // waiting for the command byte
      PH_DATA = 2'd1,   // burst in progress
      PH_DONE = 2'd2    // burst complete, further bytes ignored
   } phase_e;

   localparam logic DIR_WRITE = 1'b1;

endpackage

// File: rtl/spi_burst_shifter.sv
module spi_burst_shifter #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_n,
   input  logic              sclk,
   input  logic              mosi,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_val,
   output logic              byte_stb,
   output logic [BYTE_W-1:0] byte_val,
   output logic              tx_msb
);

   localparam int CNT_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

   generate
      if (BYTE_W < 2) begin : g_bad_width
         $error("spi_burst_shifter: BYTE_W must be at least 2");
      end
   endgenerate

   logic              sclk_d;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] rx_sr;
   logic [BYTE_W-1:0] tx_sr;
   logic              fall;
   logic              last_bit;

   assign fall     = sclk_d & ~sclk & ~frame_n;
   assign last_bit = (bit_cnt == LAST);
   assign byte_stb = fall & last_bit;
   assign byte_val = {rx_sr[BYTE_W-2:0], mosi};
   assign tx_msb   = tx_sr[BYTE_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d  <= 1'b0;
         bit_cnt <= '0;
         rx_sr   <= '0;
         tx_sr   <= '0;
      end else begin
         sclk_d <= sclk;
         if (frame_n) begin
            bit_cnt <= '0;
            rx_sr   <= '0;
            tx_sr   <= '0;
         end else begin
            if (fall) begin
               bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
               rx_sr   <= byte_val;
            end
            if (load)
               tx_sr <= load_val;
            else if (fall)
               tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
         end
      end
   end

   // R9: an idle select line leaves the bit counter cleared
   p_count_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_n |=> (bit_cnt == '0));

   // R5: a loaded value presents its MSB on the next cycle
   p_load_msb_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !frame_n) |=> (tx_msb == $past(load_val[BYTE_W-1])));

endmodule

// File: rtl/spi_burst_seq.sv
module spi_burst_seq
   import spi_burst_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int LEN_W  = 2,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_n,
   input  logic              byte_stb,
   input  logic [BYTE_W-1:0] byte_val,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic              load,
   output logic [ADDR_W-1:0] tx_addr,
   output logic              drive_en
);

   localparam int CNT_W = (1 << LEN_W) - 1;

   phase_e            phase;
   logic [ADDR_W-1:0] cur_addr;
   logic [ADDR_W-1:0] next_addr;
   logic [CNT_W-1:0]  left;
   logic              dir_wr;

   logic [LEN_W-1:0]  cmd_len;
   logic [ADDR_W-1:0] cmd_addr;
   logic              cmd_dir;

   assign cmd_len   = byte_val[BYTE_W-1 -: LEN_W];
   assign cmd_addr  = byte_val[ADDR_W:1];
   assign cmd_dir   = byte_val[0];
   assign next_addr = cur_addr + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_CMD;
         cur_addr <= '0;
         left     <= '0;
         dir_wr   <= 1'b0;
      end else if (frame_n) begin
         phase  <= PH_CMD;
         left   <= '0;
         dir_wr <= 1'b0;
      end else if (byte_stb) begin
         unique case (phase)
            PH_CMD: begin
               phase    <= PH_DATA;
               cur_addr <= cmd_addr;
               left     <= CNT_W'((1 << cmd_len) - 1);
               dir_wr   <= (cmd_dir == DIR_WRITE);
            end
            PH_DATA: begin
               cur_addr <= next_addr;
               if (left == '0)
                  phase <= PH_DONE;
               else
                  left <= left - 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign wr_en    = byte_stb & (phase == PH_DATA) & dir_wr;
   assign wr_addr  = cur_addr;
   assign load     = byte_stb & (((phase == PH_CMD) & (cmd_dir != DIR_WRITE)) |
                                 ((phase == PH_DATA) & ~dir_wr & (left != '0)));
   assign tx_addr  = (phase == PH_CMD) ? cmd_addr : next_addr;
   assign drive_en = ~frame_n & (phase == PH_DATA) & ~dir_wr;

   // R9: select high always returns to command decoding
   p_frame_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_n |=> (phase == PH_CMD));

   // R3: the final byte of a burst closes it
   p_burst_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_stb && phase == PH_DATA && left == '0) |=> (phase == PH_DONE));

   // R6: the top address wraps to zero
   p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_stb && phase == PH_DATA && cur_addr == '1) |=> (cur_addr == '0));

endmodule

// File: rtl/spi_burst_bank.sv
module spi_burst_bank #(
   parameter int ADDR_W = 5,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr_a,
   output logic [BYTE_W-1:0] rdata_a,
   input  logic [ADDR_W-1:0] raddr_b,
   output logic [BYTE_W-1:0] rdata_b
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [BYTE_W-1:0] regs [DEPTH];

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_reg
         logic [BYTE_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (we && waddr == ADDR_W'(g))
               q <= wdata;
         end
         assign regs[g] = q;
      end
   endgenerate

   assign rdata_a = regs[raddr_a];
   assign rdata_b = regs[raddr_b];

   // R4: a committed byte is present in the bank one cycle later
   p_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (regs[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/spi_burst_regs.sv
module spi_burst_regs #(
   parameter int ADDR_W = 5,
   parameter int BYTE_W = 8,
   parameter int LEN_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              mosi,
   output logic              miso,
   input  logic [ADDR_W-1:0] host_addr,
   output logic [BYTE_W-1:0] host_data
);

   generate
      if (BYTE_W != LEN_W + ADDR_W + 1) begin : g_bad_layout
         $error("spi_burst_regs: command byte must hold length, address and direction");
      end
      if (LEN_W < 1 || LEN_W > 4) begin : g_bad_len
         $error("spi_burst_regs: LEN_W out of range");
      end
   endgenerate

   logic              byte_stb;
   logic [BYTE_W-1:0] byte_val;
   logic              tx_msb;
   logic              load;
   logic [ADDR_W-1:0] tx_addr;
   logic [BYTE_W-1:0] tx_data;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic              drive_en;

   spi_burst_shifter #(.BYTE_W(BYTE_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_n  (cs_n),
      .sclk     (sclk),
      .mosi     (mosi),
      .load     (load),
      .load_val (tx_data),
      .byte_stb (byte_stb),
      .byte_val (byte_val),
      .tx_msb   (tx_msb)
   );

   spi_burst_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BYTE_W(BYTE_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_n  (cs_n),
      .byte_stb (byte_stb),
      .byte_val (byte_val),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .load     (load),
      .tx_addr  (tx_addr),
      .drive_en (drive_en)
   );

   spi_burst_bank #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wr_en),
      .waddr   (wr_addr),
      .wdata   (byte_val),
      .raddr_a (host_addr),
      .rdata_a (host_data),
      .raddr_b (tx_addr),
      .rdata_b (tx_data)
   );

   assign miso = drive_en & tx_msb;

   // R10: nothing is driven while the frame is closed
   p_miso_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !miso);

endmodule

// File: tb/spi_burst_regs_test.sv
module spi_burst_regs_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       sclk = 1'b0;
   logic       mosi = 1'b0;
   logic       miso;
   logic [4:0] host_addr = '0;
   logic [7:0] host_data;

   int checks = 0;
   int fails  = 0;
   logic [7:0] model [32];

   always #10 clk = ~clk;   // 50 MHz

   spi_burst_regs uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
      .miso(miso), .host_addr(host_addr), .host_data(host_data)
   );

   // {length code[14:13], start address[12:8], data seed[7:0]}
   localparam logic [14:0] VEC [6] = '{
      {2'b00, 5'd3,  8'hA5},
      {2'b01, 5'd10, 8'h3C},
      {2'b10, 5'd17, 8'h80},
      {2'b11, 5'd30, 8'h11},
      {2'b11, 5'd0,  8'hF0},
      {2'b00, 5'd31, 8'h7E}
   };

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic spi_bits(input logic [7:0] out, input int nbits, output logic [7:0] got);
      got = '0;
      for (int i = 0; i < nbits; i++) begin
         @(negedge clk);
         mosi = out[7-i];
         sclk = 1'b1;
         @(negedge clk);
         @(negedge clk);
         got[7-i] = miso;
         sclk = 1'b0;
         @(negedge clk);
         @(negedge clk);
      end
   endtask

   task automatic open_frame();
      @(negedge clk);
      cs_n = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic close_frame();
      @(negedge clk);
      cs_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic peek(input logic [4:0] a, output logic [7:0] d);
      @(negedge clk);
      host_addr = a;
      #1 d = host_data;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [7:0] rx;
      logic [7:0] d;
      for (int i = 0; i < 32; i++) model[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1: reset contents and idle MISO
      chk("R1", "miso after reset", miso, 1'b0);
      for (int a = 0; a < 32; a++) begin
         peek(a[4:0], d);
         chk("R1", $sformatf("reg %0d after reset", a), d, 8'h00);
      end

      // table of burst writes followed by burst reads
      for (int v = 0; v < 6; v++) begin
         logic [1:0] len = VEC[v][14:13];
         logic [4:0] base = VEC[v][12:8];
         logic [7:0] seed = VEC[v][7:0];
         int n = 1 << len;

         // R2: write command {len, addr, 1}
         open_frame();
         spi_bits({len, base, 1'b1}, 8, rx);
         chk("R10", "miso during command", rx, 8'h00);
         for (int k = 0; k < n; k++) begin
            logic [7:0] val = seed + 8'(k * 8'h13);
            model[5'(base + k)] = val;
            spi_bits(val, 8, rx);
            chk("R10", "miso during write data", rx, 8'h00);
         end
         spi_bits(8'hFF, 8, rx);           // R7: surplus byte
         chk("R7", "miso on surplus write byte", rx, 8'h00);
         close_frame();

         // R4 R6 R11: written bytes at wrapped addresses
         for (int k = 0; k < n; k++) begin
            peek(5'(base + k), d);
            chk("R4", $sformatf("vec %0d reg %0d", v, 5'(base + k)), d, model[5'(base + k)]);
         end
         // R3 R7: register just past the burst untouched
         peek(5'(base + n), d);
         chk("R3", $sformatf("vec %0d reg past burst", v), d, model[5'(base + n)]);

         // R5 R6: read back, {len, addr, 0}
         open_frame();
         spi_bits({len, base, 1'b0}, 8, rx);
         chk("R10", "miso during read command", rx, 8'h00);
         for (int k = 0; k < n; k++) begin
            spi_bits(8'h00, 8, rx);
            chk("R5", $sformatf("vec %0d read byte %0d", v, k), rx, model[5'(base + k)]);
         end
         spi_bits(8'h00, 8, rx);
         chk("R7", "miso on surplus read byte", rx, 8'h00);
         close_frame();
         chk("R10", "miso with select high", miso, 1'b0);
      end

      // R8: partial data byte dropped
      open_frame();
      spi_bits({2'b00, 5'd5, 1'b1}, 8, rx);
      spi_bits(8'h99, 5, rx);
      close_frame();
      peek(5'd5, d);
      chk("R8", "reg 5 after partial byte", d, model[5]);

      // R9: partial command then a fresh frame
      open_frame();
      spi_bits(8'hFF, 3, rx);
      close_frame();
      open_frame();
      spi_bits({2'b00, 5'd7, 1'b1}, 8, rx);
      spi_bits(8'hC3, 8, rx);
      close_frame();
      model[7] = 8'hC3;
      peek(5'd7, d);
      chk("R9", "reg 7 after fresh command", d, 8'hC3);
      peek(5'd8, d);
      chk("R9", "reg 8 untouched", d, model[8]);

      // R2: single read with length code 00 returns one byte then zero
      open_frame();
      spi_bits({2'b00, 5'd7, 1'b0}, 8, rx);
      spi_bits(8'h00, 8, rx);
      chk("R2", "single read of reg 7", rx, 8'hC3);
      spi_bits(8'h00, 8, rx);
      chk("R3", "no second byte for code 00", rx, 8'h00);
      close_frame();

      // R1: reset during operation clears the bank
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      peek(5'd7, d);
      chk("R1", "reg 7 after second reset", d, 8'h00);
      peek(5'd30, d);
      chk("R1", "reg 30 after second reset", d, 8'h00);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule